// File: doc/BRIEF.md
# Power-up write inhibit sequencer

This block decides which commands a serial flash may act on while its supply ramps up or collapses. Two digital comparator flags come in: one says the supply is above the write-inhibit threshold, the other says it is above the operating minimum. While the first flag is low, the block holds the rest of the device in reset and every command is ignored. Once the supply is valid, two independent cycle counters run. One opens read access a short select delay after the supply reaches its operating minimum. The other opens write-class commands a longer delay after the supply crosses the inhibit threshold. Write-class commands are those that set the write enable latch, program a page, erase a sector or the whole array, or write the status register.

The SPI front end gives the block a decoded command class with a valid strobe. One cycle later the block answers with accept or reject. A command that arrives while chip selection is not yet allowed gets neither answer. When the device leaves reset, the block pulses a load strobe carrying the power-up status values: standby rather than deep power-down, and write enable latch and write-in-progress both clear. If the supply drops below the inhibit threshold while the array reports a write, program or erase in progress, the block raises a sticky corruption warning. The warning stays set until it is cleared.

Top module: `pwrup_write_gate`

## Requirements
- R1: `dev_rst` is 1 in the cycle after any clock edge that samples `rst`=1 or `vwi_ok`=0, and 0 otherwise. While `dev_rst` is 1, `rd_allow` and `wr_allow` are 0.
- R2: `rd_allow` becomes 1 after RD_DLY consecutive clock edges that sample both `vwi_ok` and `vmin_ok` high. One sampled low on either flag restarts that count from zero.
- R3: The write timer reaches its limit after WR_DLY consecutive edges that sample `vwi_ok` high, and restarts from zero when `vwi_ok` is sampled low. `wr_allow` is 1 only when both the read condition of R2 and this write timer are complete.
- R4: `wr_allow` never stands at 1 while `rd_allow` is 0. With RD_DLY reached first, reads open while writes stay closed.
- R5: A command strobed while `rd_allow` is 0 is ignored: `cmd_go` and `cmd_rej` are both 0 in the following cycle.
- R6: A write-class command (`cmd_class`=2'b01) gives `cmd_go`=1 in the next cycle if `wr_allow` was 1, and `cmd_rej`=1 if only `rd_allow` was 1.
- R7: With `rd_allow`=1, read class (2'b00) and miscellaneous class (2'b10) give `cmd_go`=1, and the reserved code 2'b11 gives `cmd_rej`=1. `cmd_go` and `cmd_rej` are never both 1, and `cmd_valid`=0 gives neither.
- R8: `init_load` is 1 for exactly the first cycle in which `dev_rst` is 0 after being 1. `init_status` is {deep power-down, write in progress, write enable} = 3'b000.
- R9: `corrupt_warn` is set in the cycle after an edge that samples `dev_rst`=0, `vwi_ok`=0 and `wip_in`=1. It then holds until `warn_clr` is sampled high or `rst` is sampled high.
- R10: When a set condition and `warn_clr` are sampled on the same edge, `corrupt_warn` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vwi_ok | input | 1 | Supply above write-inhibit threshold |
| vmin_ok | input | 1 | Supply above operating minimum |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_class | input | 2 | Command class: 00 read, 01 write, 10 misc, 11 reserved |
| wip_in | input | 1 | Array reports write/program/erase in progress |
| warn_clr | input | 1 | Clears the corruption warning |
| dev_rst | output | 1 | Device-wide reset |
| rd_allow | output | 1 | Chip selection and reads allowed |
| wr_allow | output | 1 | Write-class commands allowed |
| cmd_go | output | 1 | Command accepted (one cycle after strobe) |
| cmd_rej | output | 1 | Command rejected (one cycle after strobe) |
| init_load | output | 1 | Status power-up load strobe |
| init_status | output | 3 | Power-up status values {dpd, wip, wel} |
| corrupt_warn | output | 1 | Sticky interrupted-write warning |

## Verification
The bench targets the window where reads are open but writes are closed. A design that opened both on the later delay, or both on the earlier one, would accept or reject the wrong command there. It drops `vmin_ok` for one cycle once everything is open, and checks that reads close and then reopen only after a fresh full count. It does the same with `vwi_ok`, where a timer that paused instead of restarting would reopen too early. It also checks that a reserved class is rejected, that commands during reset produce no answer at all, and that a supply drop with `wip_in` high sets the warning even when a clear arrives on the same edge. A latch that let the clear win, or that fired without `wip_in`, shows up as a wrong warning level.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

    typedef enum logic [1:0] {
        CLS_READ  = 2'b00,
        CLS_WRITE = 2'b01,
        CLS_MISC  = 2'b10,
        CLS_RSVD  = 2'b11
    } cmd_class_e;

    typedef enum logic [1:0] {
        VRD_IGNORE = 2'b00,
        VRD_ACCEPT = 2'b01,
        VRD_REJECT = 2'b10
    } verdict_e;

    // Access windows derived from the supply timers
    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
    } gate_t;

    // Status bits loaded when the device leaves reset
    typedef struct packed {
        logic deep_pd;
        logic wip;
        logic wel;
    } stat_init_t;

    localparam stat_init_t STAT_POWERUP = '{deep_pd: 1'b0, wip: 1'b0, wel: 1'b0};

    localparam int TMR_RD = 0;
    localparam int TMR_WR = 1;
    localparam int TMR_N  = 2;

    function automatic verdict_e judge(input logic valid, input cmd_class_e cls, input gate_t g);
        verdict_e v;
        if (!valid || !g.rd_ok) begin
            v = VRD_IGNORE;
        end else begin
            case (cls)
                CLS_READ:  v = VRD_ACCEPT;
                CLS_MISC:  v = VRD_ACCEPT;
                CLS_WRITE: v = g.wr_ok ? VRD_ACCEPT : VRD_REJECT;
                default:   v = VRD_REJECT;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/pwg_delay_timer.sv
module pwg_delay_timer #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic done
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM_V = W'(LIMIT);

    logic [W-1:0] cnt_q;

    // Counts consecutive armed cycles, saturates, restarts on any gap
    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM_V) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LIM_V);

    AST_TMR_DISARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !arm |=> !done) else $error("timer done after disarm"); // R2
    AST_TMR_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && arm) |=> done) else $error("timer lost done while armed"); // R3

endmodule

// File: rtl/pwg_supply_seq.sv
module pwg_supply_seq
    import pwg_pkg::*;
#(
    parameter int unsigned RD_DLY = 1000,
    parameter int unsigned WR_DLY = 100000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  vwi_ok,
    input  logic  vmin_ok,
    output logic  dev_rst,
    output logic  init_load,
    output gate_t gate
);
    localparam int unsigned LIMS [TMR_N] = '{RD_DLY, WR_DLY};

    logic [TMR_N-1:0] arm;
    logic [TMR_N-1:0] done;
    logic             dev_rst_q;
    logic             rst_hist_q;

    assign arm[TMR_RD] = vwi_ok & vmin_ok;
    assign arm[TMR_WR] = vwi_ok;

    for (genvar g = 0; g < TMR_N; g++) begin : g_tmr
        pwg_delay_timer #(.LIMIT(LIMS[g])) u_tmr (
            .clk  (clk),
            .rst  (rst),
            .arm  (arm[g]),
            .done (done[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_rst_q  <= 1'b1;
            rst_hist_q <= 1'b1;
        end else begin
            dev_rst_q  <= !vwi_ok;
            rst_hist_q <= dev_rst_q;
        end
    end

    assign dev_rst    = dev_rst_q;
    assign init_load  = rst_hist_q & ~dev_rst_q;
    assign gate.rd_ok = done[TMR_RD] & ~dev_rst_q;
    assign gate.wr_ok = gate.rd_ok & done[TMR_WR];

    AST_DROP_RESETS: assert property (@(posedge clk) disable iff (rst)
        !vwi_ok |=> dev_rst) else $error("no reset after supply drop"); // R1
    AST_RESET_CLOSES: assert property (@(posedge clk) disable iff (rst)
        dev_rst |-> !gate.rd_ok) else $error("reads open in reset"); // R1
    AST_INIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        init_load |=> !init_load) else $error("init strobe too long"); // R8

endmodule

// File: rtl/pwg_cmd_gate.sv
module pwg_cmd_gate
    import pwg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_class,
    input  gate_t      gate,
    output logic       cmd_go,
    output logic       cmd_rej
);
    verdict_e verdict;

    assign verdict = judge(cmd_valid, cmd_class_e'(cmd_class), gate);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_go  <= 1'b0;
            cmd_rej <= 1'b0;
        end else begin
            cmd_go  <= (verdict == VRD_ACCEPT);
            cmd_rej <= (verdict == VRD_REJECT);
        end
    end

    AST_NO_GO_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (cmd_go || cmd_rej) |-> $past(gate.rd_ok)) else $error("answer while deselected"); // R5
    AST_WRITE_NEEDS_WR: assert property (@(posedge clk) disable iff (rst)
        (cmd_go && $past(cmd_class) == CLS_WRITE) |-> $past(gate.wr_ok))
        else $error("write accepted early"); // R6
    AST_GO_REJ_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cmd_go && cmd_rej)) else $error("accept and reject together"); // R7

endmodule

// File: rtl/pwg_fault_latch.sv
module pwg_fault_latch (
    input  logic clk,
    input  logic rst,
    input  logic dev_rst,
    input  logic vwi_ok,
    input  logic wip_in,
    input  logic clr,
    output logic warn
);
    logic hit;

    // Supply loss while running, with an array cycle still open
    assign hit = !dev_rst && !vwi_ok && wip_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            warn <= 1'b0;
        end else if (hit) begin
            warn <= 1'b1;
        end else if (clr) begin
            warn <= 1'b0;
        end
    end

    AST_WARN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (warn && !clr) |=> warn) else $error("warning dropped"); // R9
    AST_WARN_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (!dev_rst && !vwi_ok && wip_in) |=> warn) else $error("warning missed"); // R10

endmodule

// File: rtl/pwrup_write_gate.sv
module pwrup_write_gate
    import pwg_pkg::*;
#(
    parameter int unsigned RD_DLY = 1000,
    parameter int unsigned WR_DLY = 100000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vwi_ok,
    input  logic       vmin_ok,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_class,
    input  logic       wip_in,
    input  logic       warn_clr,
    output logic       dev_rst,
    output logic       rd_allow,
    output logic       wr_allow,
    output logic       cmd_go,
    output logic       cmd_rej,
    output logic       init_load,
    output logic [2:0] init_status,
    output logic       corrupt_warn
);
    gate_t gate;

    pwg_supply_seq #(.RD_DLY(RD_DLY), .WR_DLY(WR_DLY)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .vwi_ok    (vwi_ok),
        .vmin_ok   (vmin_ok),
        .dev_rst   (dev_rst),
        .init_load (init_load),
        .gate      (gate)
    );

    pwg_cmd_gate u_cmd (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_class (cmd_class),
        .gate      (gate),
        .cmd_go    (cmd_go),
        .cmd_rej   (cmd_rej)
    );

    pwg_fault_latch u_flt (
        .clk     (clk),
        .rst     (rst),
        .dev_rst (dev_rst),
        .vwi_ok  (vwi_ok),
        .wip_in  (wip_in),
        .clr     (warn_clr),
        .warn    (corrupt_warn)
    );

    assign rd_allow    = gate.rd_ok;
    assign wr_allow    = gate.wr_ok;
    assign init_status = STAT_POWERUP;

    AST_WR_NEEDS_RD: assert property (@(posedge clk) disable iff (rst)
        wr_allow |-> rd_allow) else $error("writes open without reads"); // R4

endmodule

// File: tb/sim_pwrup_write_gate.sv
module sim_pwrup_write_gate;
    localparam int unsigned RD_DLY = 6;
    localparam int unsigned WR_DLY = 30;

    logic clk = 1'b0;
    logic rst, vwi_ok, vmin_ok, cmd_valid, wip_in, warn_clr;
    logic [1:0] cmd_class;
    logic dev_rst, rd_allow, wr_allow, cmd_go, cmd_rej, init_load, corrupt_warn;
    logic [2:0] init_status;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model state
    int  rd_run = 0, wr_run = 0;
    bit  m_rst = 1, m_rst_prev = 1, m_rd = 0, m_wr = 0, m_warn = 0;

    // {valid, class[1:0], go_ro, rej_ro, go_full, rej_full}
    localparam logic [6:0] VEC [5] = '{
        7'b1_00_10_10,
        7'b1_01_01_10,
        7'b1_10_10_10,
        7'b1_11_01_01,
        7'b0_01_00_00
    };

    always #5 clk = ~clk;

    pwrup_write_gate #(.RD_DLY(RD_DLY), .WR_DLY(WR_DLY)) u0 (
        .clk(clk), .rst(rst), .vwi_ok(vwi_ok), .vmin_ok(vmin_ok),
        .cmd_valid(cmd_valid), .cmd_class(cmd_class), .wip_in(wip_in),
        .warn_clr(warn_clr), .dev_rst(dev_rst), .rd_allow(rd_allow),
        .wr_allow(wr_allow), .cmd_go(cmd_go), .cmd_rej(cmd_rej),
        .init_load(init_load), .init_status(init_status),
        .corrupt_warn(corrupt_warn)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: advance the requirement model, then compare at the negedge
    task automatic tick();
        bit pr = m_rd, pw = m_wr, prst = m_rst;
        logic v = cmd_valid;
        logic [1:0] c = cmd_class;
        bit eg = 0, ej = 0;
        string ctag;
        @(posedge clk);
        if (rst) m_warn = 0;
        else if (!prst && !vwi_ok && wip_in) m_warn = 1;
        else if (warn_clr) m_warn = 0;
        if (rst || !vwi_ok) begin
            rd_run = 0; wr_run = 0;
        end else begin
            wr_run++;
            rd_run = vmin_ok ? rd_run + 1 : 0;
        end
        m_rst_prev = m_rst;
        m_rst = rst || !vwi_ok;
        m_rd = !m_rst && rd_run >= RD_DLY;
        m_wr = m_rd && wr_run >= WR_DLY;
        if (!rst && v && pr) begin
            if (c == 2'b01) begin eg = pw; ej = !pw; end
            else if (c == 2'b11) ej = 1;
            else eg = 1;
        end
        ctag = !pr ? "R5" : (c == 2'b01 ? "R6" : "R7");
        @(negedge clk);
        chk("R1 dev_rst", dev_rst, m_rst);
        chk("R2 rd_allow", rd_allow, m_rd);
        chk("R3 wr_allow", wr_allow, m_wr);
        chk({ctag, " cmd_go"}, cmd_go, eg);
        chk({ctag, " cmd_rej"}, cmd_rej, ej);
        chk("R8 init_load", init_load, m_rst_prev && !m_rst);
        chk("R9 corrupt_warn", corrupt_warn, m_warn);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic send(input logic v, input logic [1:0] c);
        cmd_valid = v; cmd_class = c;
        tick();
        cmd_valid = 0; cmd_class = 2'b00;
    endtask

    task automatic walk(input bit full);
        for (int i = 0; i < 5; i++) begin
            send(VEC[i][6], VEC[i][5:4]);
            chk("R6 R7 table go", cmd_go, full ? VEC[i][1] : VEC[i][3]);
            chk("R6 R7 table rej", cmd_rej, full ? VEC[i][0] : VEC[i][2]);
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; vwi_ok = 0; vmin_ok = 0; cmd_valid = 0; cmd_class = 0;
        wip_in = 0; warn_clr = 0;
        @(negedge clk);
        ticks(2);
        // R1 reset state
        chk("R1 reset dev_rst", dev_rst, 1);
        chk("R1 reset rd", rd_allow, 0);
        chk("R9 reset warn", corrupt_warn, 0);

        // supply below inhibit: commands ignored (R5)
        rst = 0;
        ticks(2);
        send(1, 2'b00);
        send(1, 2'b01);
        chk("R5 ignored in inhibit", {cmd_go, cmd_rej}, 0);

        // supply above inhibit: init strobe, R8
        vwi_ok = 1;
        tick();
        chk("R8 init strobe", init_load, 1);
        chk("R8 init status", init_status, 3'b000);
        ticks(2);
        vmin_ok = 1;
        ticks(RD_DLY);
        // R4: reads open, writes still closed
        chk("R4 read-only rd", rd_allow, 1);
        chk("R4 read-only wr", wr_allow, 0);
        walk(0);
        ticks(WR_DLY);
        chk("R3 writes open", wr_allow, 1);
        walk(1);

        // R2 restart: one-cycle dip on vmin
        vmin_ok = 0; tick(); vmin_ok = 1;
        chk("R2 dip closes rd", rd_allow, 0);
        ticks(RD_DLY - 1);
        chk("R2 not yet reopened", rd_allow, 0);
        tick();
        chk("R2 reopened", rd_allow, 1);

        // R3 restart: one-cycle dip on vwi, no array activity
        vwi_ok = 0; tick(); vwi_ok = 1;
        chk("R1 dip resets", dev_rst, 1);
        chk("R9 no warn without wip", corrupt_warn, 0);
        ticks(RD_DLY + 2);
        chk("R3 write timer restarted", wr_allow, 0);
        ticks(WR_DLY);
        chk("R3 writes reopened", wr_allow, 1);

        // R9: drop with wip set
        wip_in = 1; vwi_ok = 0; tick(); vwi_ok = 1; wip_in = 0;
        chk("R9 warn set", corrupt_warn, 1);
        ticks(4);
        chk("R9 warn sticky", corrupt_warn, 1);
        warn_clr = 1; tick(); warn_clr = 0;
        chk("R9 warn cleared", corrupt_warn, 0);

        // R10: set and clear on the same edge
        wip_in = 1; warn_clr = 1; vwi_ok = 0; tick();
        vwi_ok = 1; wip_in = 0; warn_clr = 0;
        chk("R10 set wins", corrupt_warn, 1);
        ticks(3);

        // system reset clears the warning (R9)
        rst = 1; tick(); rst = 0;
        chk("R9 rst clears warn", corrupt_warn, 0);
        ticks(3);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule